// File: doc/BRIEF.md
# Asynchronous Pseudo-Static RAM Controller

This block connects a clocked internal request port to an external pseudo-static RAM whose control pins are asynchronous and whose data bus is 16 bits wide. The RAM has two chip selects of opposite polarity. The active-low select opens an access. The active-high select keeps the part awake; taking it low puts the part into its lowest-power state.

After reset the controller holds the part quiet for a long initialization window and then activates it. Between accesses it leaves the part in standby, with both selects high. It serves one read or one write at a time, and the timing of each is set by clock-cycle parameters. It also puts the part into deep power-down and brings it back out on request.

A request is a valid/ready handshake that carries an address, a write flag, a two-bit byte mask and write data. A read returns its data together with a single-cycle response strobe. The data bus is presented as separate output, output-enable and input vectors, and the pad is assumed to combine them.

Top module: `psram_ctl`

## Requirements
- R1: During reset and for INIT_CYC clock cycles after reset release, `req_ready` is low and `mem_cs_n` and `mem_awake` are both high. The next cycle drives `mem_cs_n` low with `mem_awake` high and `req_ready` still low. The cycle after that raises `req_ready`.
- R2: While `req_ready` is high, the pins show standby: `mem_cs_n`, `mem_awake`, `mem_we_n` and `mem_oe_n` are all 1 and `mem_dq_oe` is 0.
- R3: An accepted read holds `mem_cs_n`=0, `mem_awake`=1, `mem_we_n`=1, `mem_oe_n`=0, both byte enables low and `mem_addr` equal to the request address for exactly ACC_CYC cycles, starting the cycle after acceptance.
- R4: A read samples `mem_dq_i` at the end of its last ACC_CYC cycle. In the following cycle `rsp_valid` is high for exactly one cycle with that value on `rsp_rdata`, and `req_ready` is high again.
- R5: An accepted write first spends one setup cycle with `mem_cs_n`=0 and `mem_we_n`=1. It then holds `mem_we_n`=0 for max(WP_CYC, DS_CYC) cycles with `mem_dq_oe`=1 and `mem_dq_o` equal to the request data. `mem_oe_n` stays 1 throughout.
- R6: In a write, `req_bmask` bit 1 selects the upper byte, shown on `mem_hi_n`, and bit 0 selects the lower byte, shown on `mem_lo_n`. A lane whose mask bit is 0 keeps its enable high for the whole write, so a mask of 2'b00 leaves memory unchanged.
- R7: After `mem_we_n` rises, `mem_cs_n` stays low and the data stays driven for HOLD_CYC cycles. After that, `mem_cs_n` returns high and `mem_dq_oe` drops.
- R8: `mem_dq_oe` is never high while `mem_oe_n` is low, and `mem_we_n` and `mem_oe_n` are never low together.
- R9: A `pd_req` seen while idle takes `mem_awake` low with `mem_cs_n` high and `req_ready` low from the next cycle. A `pd_req` held during an access is ignored.
- R10: When `req_valid` and `pd_req` are both high in an idle cycle, the access is served and power-down is not entered.
- R11: A `pd_exit` pulse during power-down repeats the whole R1 sequence before `req_ready` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_bmask | input | 2 | Byte lanes to write (bit 1 upper, bit 0 lower) |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W | Read data |
| pd_req | input | 1 | Enter deep power-down (taken only when idle) |
| pd_exit | input | 1 | Leave deep power-down |
| mem_cs_n | output | 1 | Active-low access select |
| mem_awake | output | 1 | Active-high select; low means deep power-down |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_hi_n | output | 1 | Active-low upper byte enable |
| mem_lo_n | output | 1 | Active-low lower byte enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_o | output | DATA_W | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for the data pad |
| mem_dq_i | input | DATA_W | Data from memory |

## Verification
The hardest case to reach is a power-down request that meets a busy or contested controller. In one case the request is raised together with a read in the same idle cycle. In the other it is held through the whole read and dropped only in the read's last cycle. The bench does both in one read and then checks that the awake select never fell. The bench's memory model also returns a poison value until the read strobe has been low for the full access time, so a capture that comes one cycle early shows up as a data mismatch in the scoreboard.

// File: rtl/psram_ctl_pkg.sv
package psram_ctl_pkg;

   typedef enum logic [2:0] {
      ST_INIT, ST_WAKE, ST_IDLE, ST_RD, ST_WSU, ST_WPW, ST_WHD, ST_PD
   } ctl_state_t;

   typedef struct packed {
      logic cs_n;
      logic awake;
      logic we_n;
      logic oe_n;
      logic lanes_on;
      logic dq_oe;
      logic ready;
   } ctl_pins_t;

   function automatic ctl_pins_t pins_of(ctl_state_t s);
      ctl_pins_t p;
      p.cs_n     = !(s inside {ST_WAKE, ST_RD, ST_WSU, ST_WPW, ST_WHD});
      p.awake    = (s != ST_PD);
      p.we_n     = (s != ST_WPW);
      p.oe_n     = (s != ST_RD);
      p.lanes_on = (s inside {ST_RD, ST_WSU, ST_WPW, ST_WHD});
      p.dq_oe    = (s inside {ST_WPW, ST_WHD});
      p.ready    = (s == ST_IDLE);
      return p;
   endfunction

endpackage

// File: rtl/psram_ctl_timer.sv
module psram_ctl_timer #(
   parameter int TW      = 16,
   parameter int RST_VAL = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          done
);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= TW'(RST_VAL);
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);

endmodule

// File: rtl/psram_ctl_seq.sv
module psram_ctl_seq
   import psram_ctl_pkg::*;
#(
   parameter int INIT_CYC  = 40000,
   parameter int ACC_CYC   = 7,
   parameter int PULSE_CYC = 5,
   parameter int HOLD_CYC  = 1,
   parameter int TW        = 16,
   parameter bit PIN_REG   = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req_valid,
   input  logic      req_write,
   input  logic      pd_req,
   input  logic      pd_exit,
   output logic      accept,
   output logic      capture,
   output ctl_pins_t pins
);

   localparam logic [TW-1:0] L_INIT = TW'(INIT_CYC - 1);
   localparam logic [TW-1:0] L_ACC  = TW'(ACC_CYC - 1);
   localparam logic [TW-1:0] L_PUL  = TW'(PULSE_CYC - 1);
   localparam logic [TW-1:0] L_HLD  = TW'(HOLD_CYC - 1);

   ctl_state_t    state, nxt;
   logic          tload, tdone;
   logic [TW-1:0] tval;

   psram_ctl_timer #(.TW(TW), .RST_VAL(INIT_CYC - 1)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tload),
      .load_val (tval),
      .done     (tdone)
   );

   always_comb begin
      nxt   = state;
      tload = 1'b0;
      tval  = '0;
      case (state)
         ST_INIT: if (tdone) nxt = ST_WAKE;
         ST_WAKE: nxt = ST_IDLE;
         ST_IDLE: begin
            if (req_valid) begin
               if (req_write) begin
                  nxt = ST_WSU;
               end else begin
                  nxt   = ST_RD;
                  tload = 1'b1;
                  tval  = L_ACC;
               end
            end else if (pd_req) begin
               nxt = ST_PD;
            end
         end
         ST_RD:   if (tdone) nxt = ST_IDLE;
         ST_WSU: begin
            nxt   = ST_WPW;
            tload = 1'b1;
            tval  = L_PUL;
         end
         ST_WPW: begin
            if (tdone) begin
               nxt   = ST_WHD;
               tload = 1'b1;
               tval  = L_HLD;
            end
         end
         ST_WHD:  if (tdone) nxt = ST_IDLE;
         ST_PD: begin
            if (pd_exit) begin
               nxt   = ST_INIT;
               tload = 1'b1;
               tval  = L_INIT;
            end
         end
         default: nxt = ST_INIT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_INIT;
      else        state <= nxt;
   end

   assign accept  = (state == ST_IDLE) && req_valid;
   assign capture = (state == ST_RD) && tdone;

   generate
      if (PIN_REG) begin : g_pin_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pins <= pins_of(ST_INIT);
            else        pins <= pins_of(nxt);
         end
      end else begin : g_pin_dec
         assign pins = pins_of(state);
      end
   endgenerate

   // R9
   pd_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PD && $past(state) != ST_PD) |-> $past(state) == ST_IDLE);

   // R10
   access_over_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && req_valid && pd_req) |=> state != ST_PD);

endmodule

// File: rtl/psram_ctl_dpath.sv
module psram_ctl_dpath #(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16,
   parameter int LANES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  logic              lanes_on,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic [LANES-1:0]  req_bmask,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] mem_dq_i,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [LANES-1:0]  mem_be_n,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);

   logic [LANES-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr <= '0;
         mem_dq_o <= '0;
         mask_q   <= '0;
      end else if (accept) begin
         mem_addr <= req_addr;
         mem_dq_o <= req_wdata;
         mask_q   <= req_write ? req_bmask : {LANES{1'b1}};
      end
   end

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign mem_be_n[g] = !(lanes_on && mask_q[g]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= capture;
         if (capture) rsp_rdata <= mem_dq_i;
      end
   end

   // R4
   rsp_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R4
   rsp_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!capture && !$past(capture)) |=> $stable(rsp_rdata));

endmodule

// File: rtl/psram_ctl.sv
module psram_ctl
   import psram_ctl_pkg::*;
#(
   parameter int ADDR_W   = 20,
   parameter int DATA_W   = 16,
   parameter int INIT_CYC = 40000,
   parameter int ACC_CYC  = 7,
   parameter int WP_CYC   = 5,
   parameter int DS_CYC   = 3,
   parameter int HOLD_CYC = 1,
   parameter bit PIN_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_bmask,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   input  logic              pd_req,
   input  logic              pd_exit,
   output logic              mem_cs_n,
   output logic              mem_awake,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic              mem_hi_n,
   output logic              mem_lo_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i
);

   localparam int LANES     = DATA_W / 8;
   localparam int PULSE_CYC = (WP_CYC > DS_CYC) ? WP_CYC : DS_CYC;
   localparam int MAX_A     = (INIT_CYC > ACC_CYC) ? INIT_CYC : ACC_CYC;
   localparam int MAX_B     = (PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC;
   localparam int MAX_C     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int TW        = $clog2(MAX_C + 1);

   generate
      if (DATA_W != 16) begin : g_bad_width
         $error("psram_ctl: DATA_W must be 16 (two byte lanes)");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("psram_ctl: ADDR_W must be at least 1");
      end
      if (INIT_CYC < 1 || ACC_CYC < 1 || WP_CYC < 1 || DS_CYC < 1 || HOLD_CYC < 1) begin : g_bad_timing
         $error("psram_ctl: all cycle counts must be at least 1");
      end
   endgenerate

   ctl_pins_t        pins;
   logic             accept, capture;
   logic [LANES-1:0] be_n;

   psram_ctl_seq #(
      .INIT_CYC  (INIT_CYC),
      .ACC_CYC   (ACC_CYC),
      .PULSE_CYC (PULSE_CYC),
      .HOLD_CYC  (HOLD_CYC),
      .TW        (TW),
      .PIN_REG   (PIN_REG)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .pd_req    (pd_req),
      .pd_exit   (pd_exit),
      .accept    (accept),
      .capture   (capture),
      .pins      (pins)
   );

   psram_ctl_dpath #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .LANES  (LANES)
   ) u_dpath (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .capture   (capture),
      .lanes_on  (pins.lanes_on),
      .req_addr  (req_addr),
      .req_write (req_write),
      .req_bmask (req_bmask),
      .req_wdata (req_wdata),
      .mem_dq_i  (mem_dq_i),
      .mem_addr  (mem_addr),
      .mem_be_n  (be_n),
      .mem_dq_o  (mem_dq_o),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

   assign req_ready = pins.ready;
   assign mem_cs_n  = pins.cs_n;
   assign mem_awake = pins.awake;
   assign mem_we_n  = pins.we_n;
   assign mem_oe_n  = pins.oe_n;
   assign mem_dq_oe = pins.dq_oe;
   assign mem_hi_n  = be_n[1];
   assign mem_lo_n  = be_n[0];

   // R8
   no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   // R8
   we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_we_n && !mem_oe_n));

   // R2
   idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_cs_n && mem_awake && mem_we_n && mem_oe_n && !mem_dq_oe));

   // R9
   pd_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_awake |-> (mem_cs_n && !req_ready));

   // R7
   write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (!mem_cs_n && mem_dq_oe));

   // R5
   write_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_cs_n && mem_awake && mem_dq_oe && !req_ready));

endmodule

// File: tb/psram_ctl_test.sv
module psram_ctl_test;

   localparam int AW  = 20;
   localparam int IC  = 40;
   localparam int AC  = 4;
   localparam int WP  = 3;
   localparam int DS  = 2;
   localparam int DH  = 2;
   localparam int PUL = (WP > DS) ? WP : DS;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0, pd_req = 1'b0, pd_exit = 1'b0;
   logic          req_ready, rsp_valid;
   logic [AW-1:0] req_addr = '0;
   logic [1:0]    req_bmask = 2'b00;
   logic [15:0]   req_wdata = '0, rsp_rdata;
   logic          mem_cs_n, mem_awake, mem_we_n, mem_oe_n, mem_hi_n, mem_lo_n, mem_dq_oe;
   logic [AW-1:0] mem_addr;
   logic [15:0]   mem_dq_o, mem_dq_i;

   int checks = 0;
   int errors = 0;
   logic [15:0] expq[$];
   logic [15:0] mm [16];
   logic [15:0] sh [16];
   int mcnt = 0;
   logic rd_act;

   always #5 clk = ~clk;

   psram_ctl #(
      .ADDR_W(AW), .DATA_W(16), .INIT_CYC(IC), .ACC_CYC(AC),
      .WP_CYC(WP), .DS_CYC(DS), .HOLD_CYC(DH), .PIN_REG(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_bmask(req_bmask),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .pd_req(pd_req), .pd_exit(pd_exit), .mem_cs_n(mem_cs_n),
      .mem_awake(mem_awake), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_hi_n(mem_hi_n), .mem_lo_n(mem_lo_n), .mem_addr(mem_addr),
      .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
   );

   function automatic logic [15:0] seed(int i);
      return 16'h0F00 ^ (16'(i) * 16'h1111);
   endfunction

   // memory model: poison until the access time has elapsed
   assign rd_act   = !mem_cs_n && mem_awake && mem_we_n && !mem_oe_n;
   assign mem_dq_i = (rd_act && mcnt >= AC - 1) ? mm[mem_addr[3:0]] : 16'hBAD0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) mm[i] <= seed(i);
         mcnt <= 0;
      end else begin
         mcnt <= rd_act ? mcnt + 1 : 0;
         if (!mem_cs_n && mem_awake && !mem_we_n && mem_dq_oe) begin
            if (!mem_hi_n) mm[mem_addr[3:0]][15:8] <= mem_dq_o[15:8];
            if (!mem_lo_n) mm[mem_addr[3:0]][7:0]  <= mem_dq_o[7:0];
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R4 response with nothing expected", {16'h0, rsp_rdata}, 32'h0);
         end else begin
            logic [15:0] e;
            e = expq.pop_front();
            chk(rsp_rdata == e, "R4 read data", {16'h0, rsp_rdata}, {16'h0, e});
         end
      end
   end

   task automatic init_seq(input string tag);
      int bad = 0;
      for (int i = 0; i < IC; i++) begin
         if (req_ready || !mem_cs_n || !mem_awake) bad++;
         @(negedge clk);
      end
      chk(bad == 0, {tag, " init hold"}, bad, 0);
      chk(!mem_cs_n && mem_awake && !req_ready, {tag, " wake cycle"},
          {mem_cs_n, mem_awake, req_ready}, 3'b010);
      @(negedge clk);
      chk(req_ready && mem_cs_n, {tag, " ready after wake"}, {req_ready, mem_cs_n}, 2'b11);
   endtask

   task automatic do_read(input logic [AW-1:0] a, input bit pd_during);
      int bad = 0;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      expq.push_back(sh[a[3:0]]);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a; pd_req = pd_during;
      @(negedge clk);
      req_valid = 1'b0;
      if (pd_during)
         chk(mem_awake && !mem_oe_n, "R10 access wins over pd_req", {mem_awake, mem_oe_n}, 2'b10);
      for (int i = 0; i < AC; i++) begin
         if (i == AC - 1) pd_req = 1'b0;
         if (!(!mem_cs_n && mem_awake && mem_we_n && !mem_oe_n && !mem_hi_n && !mem_lo_n &&
               mem_addr == a && !mem_dq_oe && !req_ready)) bad++;
         @(negedge clk);
      end
      chk(bad == 0, "R3 read pin window", bad, 0);
      chk(rsp_valid && req_ready, "R4 response timing", {rsp_valid, req_ready}, 2'b11);
      chk(mem_cs_n && mem_oe_n && !mem_dq_oe, "R2 standby after read",
          {mem_cs_n, mem_oe_n, mem_dq_oe}, 3'b110);
      @(negedge clk);
      chk(!rsp_valid, "R4 single-cycle strobe", rsp_valid, 0);
      if (pd_during) chk(mem_awake && req_ready, "R9 pd_req during access ignored",
                         {mem_awake, req_ready}, 2'b11);
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [1:0] m, input logic [15:0] d);
      int bad = 0;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_bmask = m; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_wdata = ~d;
      chk(!mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && mem_addr == a,
          "R5 write setup cycle", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b0110);
      chk(mem_hi_n == !m[1] && mem_lo_n == !m[0], "R6 lane enables in setup",
          {mem_hi_n, mem_lo_n}, {!m[1], !m[0]});
      @(negedge clk);
      for (int i = 0; i < PUL; i++) begin
         if (!(!mem_we_n && mem_oe_n && mem_dq_oe && mem_dq_o == d && !mem_cs_n &&
               mem_hi_n == !m[1] && mem_lo_n == !m[0])) bad++;
         @(negedge clk);
      end
      chk(bad == 0, "R5 R6 write pulse", bad, 0);
      bad = 0;
      for (int i = 0; i < DH; i++) begin
         if (!(mem_we_n && !mem_cs_n && mem_dq_oe && mem_dq_o == d && mem_oe_n)) bad++;
         @(negedge clk);
      end
      chk(bad == 0, "R7 write hold", bad, 0);
      chk(mem_cs_n && !mem_dq_oe && req_ready, "R7 release after hold",
          {mem_cs_n, mem_dq_oe, req_ready}, 3'b101);
      if (m[1]) sh[a[3:0]][15:8] = d[15:8];
      if (m[0]) sh[a[3:0]][7:0]  = d[7:0];
   endtask

   initial begin
      for (int i = 0; i < 16; i++) sh[i] = seed(i);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!req_ready && mem_cs_n && mem_awake && !rsp_valid && !mem_dq_oe, "R1 reset state",
          {req_ready, mem_cs_n, mem_awake, rsp_valid, mem_dq_oe}, 5'b01100);
      rst_n = 1'b1;
      init_seq("R1");

      do_read(20'h00003, 1'b0);
      do_read(20'h00004, 1'b0);
      do_write(20'h00003, 2'b11, 16'hBEEF);
      do_read(20'h00003, 1'b0);
      do_write(20'h00005, 2'b01, 16'h1234);
      do_read(20'h00005, 1'b0);
      do_write(20'h00006, 2'b10, 16'hA5C3);
      do_read(20'h00006, 1'b0);
      do_write(20'h00007, 2'b00, 16'h5555);   // R6 empty mask
      do_read(20'h00007, 1'b0);
      do_read(20'h0000A, 1'b1);               // R9 R10

      // R9 power-down entry
      @(negedge clk);
      pd_req = 1'b1;
      @(negedge clk);
      pd_req = 1'b0;
      chk(!mem_awake && mem_cs_n && !req_ready, "R9 power-down entry",
          {mem_awake, mem_cs_n, req_ready}, 3'b010);
      repeat (5) @(negedge clk);
      chk(!mem_awake && !req_ready, "R9 power-down held", {mem_awake, req_ready}, 2'b00);
      pd_exit = 1'b1;
      @(negedge clk);
      pd_exit = 1'b0;
      init_seq("R11");

      do_read(20'h00003, 1'b0);
      do_write(20'h0000F, 2'b11, 16'h0F0F);
      do_read(20'h0000F, 1'b0);
      repeat (3) @(negedge clk);
      chk(expq.size() == 0, "R4 all reads answered", expq.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule